// File: doc/BRIEF.md
# Streaming Hamming ECC generator

This block builds a Hamming-style error-correction code over bytes as they pass on a byte-wide data path with a valid strobe. It only observes the path; it never stalls it. A single-cycle clear pulse zeroes every result and arms a new run. From then on, each byte that the strobe qualifies goes into the code, until a fixed number of bytes has been taken in. After that the block stops and ignores the data path until the next clear.

Each code has two parts. The column part is a set of parity pairs over bit positions inside every byte. The line part is a set of parity pairs chosen by the index of each byte within its block. A mode input is sampled on the clear pulse and picks one of two layouts. In dual mode, one code is formed over each of two consecutive blocks of `BLOCK_BYTES` bytes, and each code goes into its own result group. In single mode, one code is formed over a block twice that length. Its line part is two bits wider, and those two extra bits are placed in the second result group, which single mode does not otherwise use. All results can be read at any time. A done flag marks the end of a run.

Top module: `ecc_stream_gen`

## Requirements
- R1: After `rst_n` is released, all result outputs and `ecc_done` read zero, and bytes presented before the first `ecc_clear` pulse change nothing.
- R2: An `ecc_clear` pulse zeroes all results and `ecc_done` on the next edge and arms a new run. A byte presented in the same cycle as the pulse is not counted.
- R3: Column parity, per byte d, XOR-accumulated over the block: bit 7 = ^d[7:4], bit 6 = ^d[3:0], bit 5 = ^{d[7:6],d[3:2]}, bit 4 = ^{d[5:4],d[1:0]}, bit 3 = ^{d[7],d[5],d[3],d[1]}, bit 2 = ^{d[6],d[4],d[2],d[0]}. Bits 1:0 always read zero.
- R4: Line parity: for each accepted byte with odd bit parity and each index bit k, bit 2k+1 toggles when index bit k is 1, and bit 2k toggles when it is 0. For the default 256-byte block this gives 16 bits, with bits 7:0 in the low byte.
- R5: In dual mode (`mode_single`=0 at the clear), byte numbers 0 to BLOCK_BYTES-1 feed group 0 and the following BLOCK_BYTES bytes feed group 1, each using its index within its own block. Group 1 holds its value during the first block, and group 0 holds its value during the second.
- R6: In single mode, one code covers all 2*BLOCK_BYTES bytes and its index has one more bit. Line bits below 2*log2(BLOCK_BYTES) appear on `res0_line`. The two top line bits appear on `res1_line[1:0]`. The rest of `res1_line`, and all of `res1_col`, stay zero.
- R7: After 2*BLOCK_BYTES bytes have been accepted, further bytes leave every output unchanged until the next clear.
- R8: `ecc_done` rises on the edge that accepts the last byte of a run and drops on the edge after a clear pulse.
- R9: Changes to `mode_single` between clear pulses have no effect on the run in progress.
- R10: Cycles with `in_valid` low neither advance the byte count nor alter any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_clear | input | 1 | One-cycle pulse: zero results and arm a run |
| mode_single | input | 1 | Layout picked at the clear: 1 = one long block, 0 = two blocks |
| in_valid | input | 1 | Qualifies `in_data` this cycle |
| in_data | input | 8 | Byte on the observed data path |
| res0_line | output | 2*log2(BLOCK_BYTES) | Line parity of group 0 |
| res0_col | output | 8 | Column parity of group 0, in bits 7:2 |
| res1_line | output | 2*log2(BLOCK_BYTES) | Line parity of group 1, or the top two single-mode line bits |
| res1_col | output | 8 | Column parity of group 1, in bits 7:2 |
| ecc_done | output | 1 | A run has consumed its full byte count |

## Verification
The bench builds the block with `BLOCK_BYTES` = 16. This shrinks a full run to 32 bytes, so the group switch, the top pair of the single-mode index, the stop after the last byte and the bytes that arrive after it all occur within a few hundred cycles, several times over. At this size the line part is 8 bits and the single-mode index is 5 bits. Those values can be computed by hand for the directed checks, while the behavioural model covers every cycle of the gap-laden random streams.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    // Six column parity bits, ordered as they sit in bits 7:2 of a result byte
    typedef logic [5:0] col_par_t;

    // Fixed value of the two unused low bits of a column result byte
    localparam logic [1:0] COL_PAD = 2'b00;

endpackage

// File: rtl/ecc_col_calc.sv
module ecc_col_calc
    import ecc_pkg::*;
(
    input  logic [7:0] data_in,
    output col_par_t   col_out
);

    // Pairs over halves, quarters and alternate bits; upper/odd member first
    always_comb begin
        col_out[5] = ^data_in[7:4];
        col_out[4] = ^data_in[3:0];
        col_out[3] = ^{data_in[7:6], data_in[3:2]};
        col_out[2] = ^{data_in[5:4], data_in[1:0]};
        col_out[1] = ^{data_in[7], data_in[5], data_in[3], data_in[1]};
        col_out[0] = ^{data_in[6], data_in[4], data_in[2], data_in[0]};
    end

endmodule

// File: rtl/ecc_line_calc.sv
module ecc_line_calc #(
    parameter int IDX_W = 8
) (
    input  logic [7:0]         data_in,
    input  logic [IDX_W-1:0]   idx_in,
    output logic [2*IDX_W-1:0] toggle_out
);

    logic odd_byte;

    assign odd_byte = ^data_in;

    // One pair per index bit: odd member follows the bit, even member its inverse
    for (genvar k = 0; k < IDX_W; k++) begin : g_pair
        assign toggle_out[2*k+1] = odd_byte &  idx_in[k];
        assign toggle_out[2*k]   = odd_byte & ~idx_in[k];
    end

endmodule

// File: rtl/ecc_stream_gen.sv
module ecc_stream_gen
    import ecc_pkg::*;
#(
    parameter int BLOCK_BYTES = 256
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               ecc_clear,
    input  logic                               mode_single,
    input  logic                               in_valid,
    input  logic [7:0]                         in_data,
    output logic [2*$clog2(BLOCK_BYTES)-1:0]   res0_line,
    output logic [7:0]                         res0_col,
    output logic [2*$clog2(BLOCK_BYTES)-1:0]   res1_line,
    output logic [7:0]                         res1_col,
    output logic                               ecc_done
);

    localparam int IDX_W  = $clog2(BLOCK_BYTES);
    localparam int LINE_W = 2 * IDX_W;
    localparam int TOTAL  = 2 * BLOCK_BYTES;
    localparam int CNT_W  = IDX_W + 2;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TOTAL - 1);

    typedef struct packed {
        logic              armed;
        logic              single;
        logic              done;
        logic [CNT_W-1:0]  cnt;
        logic [LINE_W+1:0] line0;
        col_par_t          col0;
        logic [LINE_W-1:0] line1;
        col_par_t          col1;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic               take;
    logic [IDX_W:0]     idx_full;
    col_par_t           col_byte;
    logic [LINE_W+1:0]  tog_full;
    logic [LINE_W-1:0]  tog_half;

    assign take     = st_q.armed & in_valid;
    assign idx_full = st_q.cnt[IDX_W:0];

    ecc_col_calc u_col (
        .data_in (in_data),
        .col_out (col_byte)
    );

    ecc_line_calc #(.IDX_W(IDX_W + 1)) u_line_full (
        .data_in    (in_data),
        .idx_in     (idx_full),
        .toggle_out (tog_full)
    );

    ecc_line_calc #(.IDX_W(IDX_W)) u_line_half (
        .data_in    (in_data),
        .idx_in     (idx_full[IDX_W-1:0]),
        .toggle_out (tog_half)
    );

    always_comb begin
        st_d = st_q;
        if (ecc_clear) begin
            st_d        = '0;
            st_d.armed  = 1'b1;
            st_d.single = mode_single;
        end else if (take) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.single) begin
                st_d.line0 = st_q.line0 ^ tog_full;
                st_d.col0  = st_q.col0 ^ col_byte;
            end else if (!idx_full[IDX_W]) begin
                st_d.line0[LINE_W-1:0] = st_q.line0[LINE_W-1:0] ^ tog_half;
                st_d.col0              = st_q.col0 ^ col_byte;
            end else begin
                st_d.line1 = st_q.line1 ^ tog_half;
                st_d.col1  = st_q.col1 ^ col_byte;
            end
            if (st_q.cnt == LAST_CNT) begin
                st_d.armed = 1'b0;
                st_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res0_line = st_q.line0[LINE_W-1:0];
    assign res0_col  = {st_q.col0, COL_PAD};
    assign res1_line = st_q.single
                     ? {{(LINE_W-2){1'b0}}, st_q.line0[LINE_W+1:LINE_W]}
                     : st_q.line1;
    assign res1_col  = {st_q.col1, COL_PAD};
    assign ecc_done  = st_q.done;

    // R8
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ecc_done) |-> $past(take));

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clear |=> (res0_line == '0 && res0_col == '0 && res1_line == '0
                       && res1_col == '0 && !ecc_done));

    // R7
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_done && !ecc_clear) |=> ($stable(res0_line) && $stable(res0_col)
                                      && $stable(res1_line) && $stable(res1_col)
                                      && ecc_done));

    // R5
    grp1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_clear && st_q.armed && !st_q.single && !st_q.cnt[IDX_W])
        |=> ($stable(res1_line) && $stable(res1_col)));

    // R5
    grp0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_clear && !st_q.single && st_q.cnt[IDX_W])
        |=> ($stable(res0_line) && $stable(res0_col)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_clear && !in_valid) |=> ($stable(st_q.cnt) && $stable(res0_line)
                                       && $stable(res1_line)));

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(TOTAL));

endmodule

// File: tb/ecc_stream_gen_bench.sv
module ecc_stream_gen_bench;

    localparam int B      = 16;
    localparam int IW     = $clog2(B);
    localparam int LW     = 2 * IW;
    localparam int TOT    = 2 * B;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ecc_clear = 1'b0;
    logic          mode_single = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic [LW-1:0] res0_line, res1_line;
    logic [7:0]    res0_col, res1_col;
    logic          ecc_done;

    int checks = 0;
    int failures = 0;
    string phase = "R1";
    int seed = 12345;
    bit finished = 0;

    always #2 clk = ~clk;

    ecc_stream_gen #(.BLOCK_BYTES(B)) u_ecc_stream_gen (
        .clk, .rst_n, .ecc_clear, .mode_single, .in_valid, .in_data,
        .res0_line, .res0_col, .res1_line, .res1_col, .ecc_done
    );

    // Behavioural model
    bit  m_armed, m_single, m_done;
    byte unsigned mq[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_armed = 0; m_single = 0; m_done = 0; mq.delete();
        end else if (ecc_clear) begin
            mq.delete(); m_armed = 1; m_single = mode_single; m_done = 0;
        end else if (m_armed && in_valid) begin
            mq.push_back(in_data);
            if (mq.size() == TOT) begin
                m_armed = 0; m_done = 1;
            end
        end
    end

    function automatic void calc(input int first, input int last, input int ib,
                                 output int line, output int col);
        line = 0; col = 0;
        for (int i = first; i < last; i++) begin
            int d = mq[i];
            int idx = i - first;
            int par = 0;
            for (int b = 0; b < 8; b++) begin
                if ((d >> b) & 1) begin
                    par ^= 1;
                    col ^= (b >= 4) ? 8'h80 : 8'h40;
                    col ^= ((b & 2) != 0) ? 8'h20 : 8'h10;
                    col ^= ((b & 1) != 0) ? 8'h08 : 8'h04;
                end
            end
            if (par != 0)
                for (int k = 0; k < ib; k++)
                    line ^= ((idx >> k) & 1) ? (1 << (2*k+1)) : (1 << (2*k));
        end
    endfunction

    task automatic expect_all(output int e0l, output int e0c,
                              output int e1l, output int e1c);
        int n = mq.size();
        int l, c;
        if (m_single) begin
            calc(0, n, IW + 1, l, c);
            e0l = l & ((1 << LW) - 1); e0c = c; e1l = l >> LW; e1c = 0;
        end else begin
            calc(0, (n < B) ? n : B, IW, l, c);
            e0l = l; e0c = c;
            if (n > B) begin
                calc(B, n, IW, l, c); e1l = l; e1c = c;
            end else begin
                e1l = 0; e1c = 0;
            end
        end
    endtask

    task automatic check_eq(input string tag, input string what,
                            input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int e0l, e0c, e1l, e1c;
            expect_all(e0l, e0c, e1l, e1c);
            check_eq(phase, "res0_line", int'(res0_line), e0l);
            check_eq(phase, "res0_col", int'(res0_col), e0c);
            check_eq(phase, "res1_line", int'(res1_line), e1l);
            check_eq(phase, "res1_col", int'(res1_col), e1c);
            check_eq(phase, "done", int'(ecc_done), int'(m_done));
        end
    end

    task automatic drive(input bit clr, input bit md, input bit v, input int d);
        @(negedge clk);
        ecc_clear = clr; mode_single = md; in_valid = v; in_data = d[7:0];
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fffffff;
    endfunction

    task automatic stream(input int n, input bit md, input bit flip_mode);
        int sent = 0;
        while (sent < n) begin
            if (rnd() % 4 == 0) drive(0, flip_mode ? ~md : md, 0, rnd());
            else begin drive(0, flip_mode ? (rnd() % 2 == 1) : md, 1, rnd()); sent++; end
        end
        drive(0, md, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int l0, c0, l1, c1;
        // R1: reset state
        repeat (3) @(negedge clk);
        check_eq("R1", "reset res0_line", int'(res0_line), 0);
        check_eq("R1", "reset done", int'(ecc_done), 0);
        rst_n = 1'b1;
        phase = "R1";
        for (int i = 0; i < 4; i++) drive(0, 0, 1, 8'h01 + i);
        drive(0, 0, 0, 0);
        check_eq("R1", "pre-clear res0_line", int'(res0_line), 0);
        check_eq("R1", "pre-clear res0_col", int'(res0_col), 0);

        // R3 / R4 directed: byte 0x01 at index 0
        phase = "R3";
        drive(1, 0, 0, 0);
        drive(0, 0, 1, 8'h01);
        drive(0, 0, 0, 0);
        check_eq("R4", "line of 0x01 at index 0", int'(res0_line), 8'h55);
        check_eq("R3", "col of 0x01", int'(res0_col), 8'h54);
        // second byte 0xFF at index 1: even parity, no change
        drive(0, 0, 1, 8'hFF);
        drive(0, 0, 0, 0);
        check_eq("R4", "even byte leaves line", int'(res0_line), 8'h55);
        check_eq("R3", "0xFF leaves col", int'(res0_col), 8'h54);
        // R10: idle cycles
        phase = "R10";
        repeat (5) drive(0, 1, 0, 8'h37);
        check_eq("R10", "idle keeps line", int'(res0_line), 8'h55);

        // R5: dual mode full run with gaps
        phase = "R5";
        drive(1, 0, 0, 0);
        stream(TOT, 0, 0);
        check_eq("R8", "done after full run", int'(ecc_done), 1);
        l0 = res0_line; c0 = res0_col; l1 = res1_line; c1 = res1_col;
        // R7: extra bytes ignored
        phase = "R7";
        for (int i = 0; i < 6; i++) drive(0, 0, 1, 8'h81 + 3*i);
        drive(0, 0, 0, 0);
        check_eq("R7", "res0_line frozen", int'(res0_line), l0);
        check_eq("R7", "res0_col frozen", int'(res0_col), c0);
        check_eq("R7", "res1_line frozen", int'(res1_line), l1);
        check_eq("R7", "res1_col frozen", int'(res1_col), c1);

        // R2: clear with a byte in the same cycle, single mode
        phase = "R2";
        drive(1, 1, 1, 8'h01);
        drive(0, 1, 0, 0);
        check_eq("R2", "clear zeroes res0_line", int'(res0_line), 0);
        check_eq("R8", "clear drops done", int'(ecc_done), 0);
        // R6 and R9: single mode with mode input toggling mid-run
        phase = "R6";
        stream(TOT / 2, 1, 0);
        phase = "R9";
        stream(TOT / 2 + 3, 1, 1);
        check_eq("R6", "single mode done", int'(ecc_done), 1);
        check_eq("R6", "single res1_col zero", int'(res1_col), 0);

        // R6 directed: single odd byte at index 2B-1 sets top odd bit
        phase = "R6";
        drive(1, 1, 0, 0);
        for (int i = 0; i < TOT - 1; i++) drive(0, 1, 1, 8'h00);
        drive(0, 1, 1, 8'h80);
        drive(0, 1, 0, 0);
        check_eq("R6", "top pair on res1_line", int'(res1_line), 2);
        check_eq("R6", "low line for index 2B-1", int'(res0_line), 8'hAA);

        // restart mid-run in dual mode
        phase = "R2";
        drive(1, 0, 0, 0);
        stream(7, 0, 0);
        drive(1, 0, 0, 0);
        phase = "R5";
        stream(TOT, 0, 0);
        repeat (3) drive(0, 0, 0, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule